// File: doc/BRIEF.md
# Pixel Crop, Bias and Spaxel Binning Stage

This block sits in the streaming path of one half of a detector frame. It takes raw samples tagged with their row and column and keeps only those inside a programmable rectangular window whose column is not masked. It removes a common bias from each kept sample, treats any result above a programmable linear-region ceiling as saturated, and sums the remaining samples into square bins of BIN_N by BIN_N pixels. Each bin is called a spaxel.

A finished spaxel leaves on a valid/ready stream. It carries its sum, how many pixels went into that sum, and a flag that marks a spaxel in which every pixel that got past the mask was saturated. Later stages can use the count to rescale the sum. Pixels must arrive in raster order: rows top to bottom, and within a row, columns left to right. The window and the column mask are set while no frame is streaming. A frame-start pulse, given while the stream is idle, throws away any partly built spaxels left from an earlier frame.

Top module: `spaxel_binner`

## Requirements
- R1: A pixel outside the inclusive window rows `cfg_row_first..cfg_row_last`, columns `cfg_col_first..cfg_col_last`, changes no output and never causes an output.
- R2: A pixel whose absolute column c has bit c of `cfg_col_mask` set to 1 adds nothing to the sum, the count or the flag of its spaxel.
- R3: The corrected value of a pixel is `pix_data - cfg_bias` when `pix_data > cfg_bias`, and 0 otherwise. It never wraps.
- R4: `sp_sum` is the sum of the corrected values of the unmasked, unsaturated pixels of the spaxel. `sp_count` is the number of those pixels, at most BIN_N*BIN_N.
- R5: A pixel whose corrected value is strictly greater than `cfg_sat_limit` is saturated. It is left out of both `sp_sum` and `sp_count`.
- R6: `sp_allsat` is 1 exactly when the spaxel has at least one saturated, unmasked pixel and `sp_count` is 0.
- R7: Spaxel (i,j) covers window rows i*BIN_N..i*BIN_N+BIN_N-1 and window columns j*BIN_N..j*BIN_N+BIN_N-1, counted from the window's first row and column. It is output once, after its bottom-right pixel is accepted, with `sp_band` = j. Output order is raster order over (i,j). A spaxel that is cut off by the window edge is never output.
- R8: A `frame_start` pulse discards every partial spaxel. Spaxels built afterwards contain only pixels accepted after the pulse.
- R9: While `sp_valid` is high and `sp_ready` is low, the output fields hold steady and `pix_ready` is low. No spaxel is lost under any backpressure.
- R10: After reset, `sp_valid` is 0 and `pix_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears partial spaxels; pulse while idle |
| pix_valid | input | 1 | Input sample present |
| pix_ready | output | 1 | Input sample accepted this cycle when valid |
| pix_row | input | ROW_W | Sample row |
| pix_col | input | COL_W | Sample column |
| pix_data | input | DATA_W | Raw sample |
| cfg_row_first | input | ROW_W | First window row |
| cfg_row_last | input | ROW_W | Last window row |
| cfg_col_first | input | COL_W | First window column |
| cfg_col_last | input | COL_W | Last window column |
| cfg_bias | input | DATA_W | Bias removed from each sample |
| cfg_sat_limit | input | DATA_W | Highest corrected value still linear |
| cfg_col_mask | input | NCOLS | One bit per column; 1 drops the column |
| sp_valid | output | 1 | Spaxel result present |
| sp_ready | input | 1 | Downstream takes the result |
| sp_sum | output | ACC_W | Sum of counted pixels |
| sp_count | output | CNT_W | Number of counted pixels |
| sp_allsat | output | 1 | Every unmasked pixel was saturated |
| sp_band | output | BAND_W | Spaxel column index within the window |

## Verification
The bench builds the block with 16 rows, 16 columns, 16-bit samples and a bin size of 3. At that size every pixel of every frame can be streamed and every spaxel result can be compared against a sum the bench computes itself. The small geometry brings several cases within reach: windows whose width and height are not multiples of the bin size, masked columns both inside and outside the window, a bias above every sample, and spaxels where every pixel is saturated. It also covers a frame abandoned partway through and followed by a frame-start pulse. Three output-stall patterns, from none to heavy, check that results hold steady and that none are lost.

// File: rtl/spaxbin_pkg.sv
package spaxbin_pkg;

  localparam int unsigned SB_DATA_W_DEF = 16;
  localparam int unsigned SB_BIN_N_DEF  = 5;

  // Sum width: one sample width plus growth for BIN_N*BIN_N terms.
  function automatic int unsigned sb_acc_width(int unsigned dw, int unsigned n);
    return dw + $clog2(n * n);
  endfunction

  // Counter width able to hold the value BIN_N*BIN_N.
  function automatic int unsigned sb_cnt_width(int unsigned n);
    return $clog2(n * n + 1);
  endfunction

endpackage

// File: rtl/spx_qualify.sv
// Combinational per-pixel decode: window test, mask, bias removal,
// saturation test and position of the pixel inside its bin.
module spx_qualify #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = 9,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned NCOLS  = 256,
  parameter int unsigned BIN_N  = 5,
  parameter int unsigned BAND_W = 6
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] data,
  input  logic [ROW_W-1:0]  win_row_lo,
  input  logic [ROW_W-1:0]  win_row_hi,
  input  logic [COL_W-1:0]  win_col_lo,
  input  logic [COL_W-1:0]  win_col_hi,
  input  logic [DATA_W-1:0] bias,
  input  logic [DATA_W-1:0] sat_limit,
  input  logic [NCOLS-1:0]  col_mask,
  output logic              in_win,
  output logic              keep,
  output logic              sat_hit,
  output logic [DATA_W-1:0] value,
  output logic [BAND_W-1:0] band,
  output logic              first_col,
  output logic              last_col,
  output logic              last_row
);
  localparam logic [ROW_W-1:0] N_ROW = ROW_W'(BIN_N);
  localparam logic [COL_W-1:0] N_COL = COL_W'(BIN_N);

  logic [ROW_W-1:0] row_off, row_ph;
  logic [COL_W-1:0] col_off, col_ph, band_full;
  logic             masked, over;

  always_comb begin
    in_win    = (row >= win_row_lo) && (row <= win_row_hi) &&
                (col >= win_col_lo) && (col <= win_col_hi);
    row_off   = row - win_row_lo;
    col_off   = col - win_col_lo;
    row_ph    = row_off % N_ROW;
    col_ph    = col_off % N_COL;
    band_full = col_off / N_COL;
    band      = band_full[BAND_W-1:0];
    first_col = (col_ph == '0);
    last_col  = (col_ph == N_COL - 1'b1);
    last_row  = (row_ph == N_ROW - 1'b1);
    masked    = col_mask[col];
    value     = (data > bias) ? (data - bias) : '0;
    over      = (value > sat_limit);
    keep      = in_win && !masked && !over;
    sat_hit   = in_win && !masked && over;
  end

endmodule

// File: rtl/spx_row_acc.sv
// Sums the BIN_N columns of one bin within a single row, then hands the
// row-slice of the bin to the merge stage as a registered operation.
module spx_row_acc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 21,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned BAND_W = 6,
  parameter int unsigned BIN_N  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              step,
  input  logic              first_col,
  input  logic              last_col,
  input  logic              last_row,
  input  logic              keep,
  input  logic              sat_hit,
  input  logic [DATA_W-1:0] value,
  input  logic [BAND_W-1:0] band,
  output logic              op_valid,
  output logic [BAND_W-1:0] op_band,
  output logic              op_last_row,
  output logic [ACC_W-1:0]  op_sum,
  output logic [CNT_W-1:0]  op_cnt,
  output logic              op_sat
);
  logic [ACC_W-1:0] h_sum, n_sum;
  logic [CNT_W-1:0] h_cnt, n_cnt;
  logic             h_sat, n_sat;

  always_comb begin
    n_sum = (first_col ? '0 : h_sum) + (keep ? ACC_W'(value) : '0);
    n_cnt = (first_col ? '0 : h_cnt) + CNT_W'(keep);
    n_sat = (first_col ? 1'b0 : h_sat) | sat_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sum       <= '0;
      h_cnt       <= '0;
      h_sat       <= 1'b0;
      op_valid    <= 1'b0;
      op_band     <= '0;
      op_last_row <= 1'b0;
      op_sum      <= '0;
      op_cnt      <= '0;
      op_sat      <= 1'b0;
    end else begin
      if (adv) op_valid <= step && last_col;
      if (step) begin
        if (last_col) begin
          op_band     <= band;
          op_last_row <= last_row;
          op_sum      <= n_sum;
          op_cnt      <= n_cnt;
          op_sat      <= n_sat;
        end else begin
          h_sum <= n_sum;
          h_cnt <= n_cnt;
          h_sat <= n_sat;
        end
      end
    end
  end

  AST_ROW_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_cnt <= CNT_W'(BIN_N))); // R4

endmodule

// File: rtl/spx_linebuf.sv
// One entry per bin column: partial spaxel sums for the current band of
// rows. Synchronous read port so the array maps to block RAM; occupancy
// tags live in flops so a frame restart clears them in one cycle.
module spx_linebuf #(
  parameter int unsigned DEPTH = 52,
  parameter int unsigned AW    = 6,
  parameter int unsigned WIDTH = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             kill_en,
  input  logic [AW-1:0]    kill_addr,
  input  logic [AW-1:0]    tag_addr,
  output logic             tag_out
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] tags;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      tags <= '0;
    end else begin
      if (wr_en)   tags[wr_addr]   <= 1'b1;
      if (kill_en) tags[kill_addr] <= 1'b0;
    end
  end

  assign tag_out = tags[tag_addr];

endmodule

// File: rtl/spaxel_binner.sv
module spaxel_binner
  import spaxbin_pkg::*;
#(
  parameter  int unsigned DATA_W   = SB_DATA_W_DEF,
  parameter  int unsigned NROWS    = 512,
  parameter  int unsigned NCOLS    = 256,
  parameter  int unsigned BIN_N    = SB_BIN_N_DEF,
  localparam int unsigned ROW_W    = $clog2(NROWS),
  localparam int unsigned COL_W    = $clog2(NCOLS),
  localparam int unsigned ACC_W    = sb_acc_width(DATA_W, BIN_N),
  localparam int unsigned CNT_W    = sb_cnt_width(BIN_N),
  localparam int unsigned LB_DEPTH = (NCOLS + BIN_N - 1) / BIN_N,
  localparam int unsigned BAND_W   = (LB_DEPTH > 1) ? $clog2(LB_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [ROW_W-1:0]  pix_row,
  input  logic [COL_W-1:0]  pix_col,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [ROW_W-1:0]  cfg_row_first,
  input  logic [ROW_W-1:0]  cfg_row_last,
  input  logic [COL_W-1:0]  cfg_col_first,
  input  logic [COL_W-1:0]  cfg_col_last,
  input  logic [DATA_W-1:0] cfg_bias,
  input  logic [DATA_W-1:0] cfg_sat_limit,
  input  logic [NCOLS-1:0]  cfg_col_mask,
  output logic              sp_valid,
  input  logic              sp_ready,
  output logic [ACC_W-1:0]  sp_sum,
  output logic [CNT_W-1:0]  sp_count,
  output logic              sp_allsat,
  output logic [BAND_W-1:0] sp_band
);
  localparam int unsigned WORD_W = ACC_W + CNT_W + 1;

  // Stage A decode
  logic              q_in_win, q_keep, q_sat, q_first, q_last_col, q_last_row;
  logic [DATA_W-1:0] q_value;
  logic [BAND_W-1:0] q_band;
  logic              adv, step;

  // Stage B operation
  logic              op_valid, op_last_row, op_sat;
  logic [BAND_W-1:0] op_band;
  logic [ACC_W-1:0]  op_sum;
  logic [CNT_W-1:0]  op_cnt;

  // Line buffer interface
  logic [WORD_W-1:0] lb_rd, lb_wr;
  logic              lb_tag, fire, wr_en, kill_en;
  logic [ACC_W-1:0]  old_sum, m_sum;
  logic [CNT_W-1:0]  old_cnt, m_cnt;
  logic              old_sat, m_sat;

  assign adv       = !sp_valid || sp_ready;
  assign pix_ready = adv;
  assign step      = pix_valid && adv && q_in_win;

  spx_qualify #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .NCOLS(NCOLS), .BIN_N(BIN_N), .BAND_W(BAND_W)
  ) u_qual (
    .row(pix_row), .col(pix_col), .data(pix_data),
    .win_row_lo(cfg_row_first), .win_row_hi(cfg_row_last),
    .win_col_lo(cfg_col_first), .win_col_hi(cfg_col_last),
    .bias(cfg_bias), .sat_limit(cfg_sat_limit), .col_mask(cfg_col_mask),
    .in_win(q_in_win), .keep(q_keep), .sat_hit(q_sat), .value(q_value),
    .band(q_band), .first_col(q_first), .last_col(q_last_col),
    .last_row(q_last_row)
  );

  spx_row_acc #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
    .BAND_W(BAND_W), .BIN_N(BIN_N)
  ) u_racc (
    .clk(clk), .rst(rst), .adv(adv), .step(step),
    .first_col(q_first), .last_col(q_last_col), .last_row(q_last_row),
    .keep(q_keep), .sat_hit(q_sat), .value(q_value), .band(q_band),
    .op_valid(op_valid), .op_band(op_band), .op_last_row(op_last_row),
    .op_sum(op_sum), .op_cnt(op_cnt), .op_sat(op_sat)
  );

  spx_linebuf #(
    .DEPTH(LB_DEPTH), .AW(BAND_W), .WIDTH(WORD_W)
  ) u_lbuf (
    .clk(clk), .rst(rst), .clr_all(frame_start),
    .rd_en(step && q_last_col), .rd_addr(q_band), .rd_data(lb_rd),
    .wr_en(wr_en), .wr_addr(op_band), .wr_data(lb_wr),
    .kill_en(kill_en), .kill_addr(op_band),
    .tag_addr(op_band), .tag_out(lb_tag)
  );

  // Stage B: merge the row slice with the stored partial spaxel.
  always_comb begin
    {old_sum, old_cnt, old_sat} = lb_tag ? lb_rd : '0;
    m_sum   = op_sum + old_sum;
    m_cnt   = op_cnt + old_cnt;
    m_sat   = op_sat | old_sat;
    lb_wr   = {m_sum, m_cnt, m_sat};
    fire    = adv && op_valid;
    wr_en   = fire && !op_last_row;
    kill_en = fire && op_last_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_valid  <= 1'b0;
      sp_sum    <= '0;
      sp_count  <= '0;
      sp_allsat <= 1'b0;
      sp_band   <= '0;
    end else if (adv) begin
      sp_valid <= op_valid && op_last_row;
      if (kill_en) begin
        sp_sum    <= m_sum;
        sp_count  <= m_cnt;
        sp_allsat <= m_sat && (m_cnt == '0);
        sp_band   <= op_band;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sp_valid && !sp_ready) |=> (sp_valid && $stable(sp_sum) &&
      $stable(sp_count) && $stable(sp_allsat) && $stable(sp_band))); // R9

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    sp_valid |-> (sp_count <= CNT_W'(BIN_N * BIN_N))); // R4

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sp_valid && sp_count == '0) |-> (sp_sum == '0)); // R4

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sp_valid && pix_ready)); // R10

endmodule

// File: tb/spaxel_binner_tb.sv
`timescale 1ns/1ps
module spaxel_binner_tb;
  localparam int DATA_W = 16;
  localparam int NR     = 16;
  localparam int NC     = 16;
  localparam int BN     = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [3:0]  pix_row = '0;
  logic [3:0]  pix_col = '0;
  logic [15:0] pix_data = '0;
  logic [3:0]  rf = '0, rl = '0, cf = '0, cl = '0;
  logic [15:0] bias = '0, lim = '0;
  logic [15:0] mask = '0;
  logic        sp_valid;
  logic        sp_ready = 1'b1;
  logic [19:0] sp_sum;
  logic [3:0]  sp_count;
  logic        sp_allsat;
  logic [2:0]  sp_band;

  always #2.5 clk = ~clk;

  spaxel_binner #(.DATA_W(DATA_W), .NROWS(NR), .NCOLS(NC), .BIN_N(BN)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_row(pix_row), .pix_col(pix_col), .pix_data(pix_data),
    .cfg_row_first(rf), .cfg_row_last(rl), .cfg_col_first(cf), .cfg_col_last(cl),
    .cfg_bias(bias), .cfg_sat_limit(lim), .cfg_col_mask(mask),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_sum(sp_sum),
    .sp_count(sp_count), .sp_allsat(sp_allsat), .sp_band(sp_band)
  );

  int checks = 0, fails = 0, stall_err = 0;
  int e_sum[64], e_cnt[64], e_flag[64], e_band[64], e_n;
  int g_sum[64], g_cnt[64], g_flag[64], g_band[64], g_n;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int pixval(int mode, int r, int c);
    case (mode)
      0: return ((r * 16 + c) * 3) % 97 + 1;
      1: return ((r * 7 + c * 13) % 64) * 4;
      2: return 40000;
      default: return (r + c) % 50 + 1;
    endcase
  endfunction

  // Expected spaxels from R2-R7, for the rows actually streamed.
  task automatic compute_exp(int mode, int rows_sent);
    int nsr = (int'(rl) - int'(rf) + 1) / BN;
    int nb  = (int'(cl) - int'(cf) + 1) / BN;
    e_n = 0;
    for (int sr = 0; sr < nsr; sr++) begin
      if (int'(rf) + sr * BN + BN - 1 < rows_sent) begin
        for (int sb = 0; sb < nb; sb++) begin
          int s = 0, n = 0, st = 0;
          for (int dr = 0; dr < BN; dr++) begin
            for (int dc = 0; dc < BN; dc++) begin
              int r = int'(rf) + sr * BN + dr;
              int c = int'(cf) + sb * BN + dc;
              int v = pixval(mode, r, c);
              int corr = (v > int'(bias)) ? v - int'(bias) : 0;
              if (!mask[c]) begin
                if (corr > int'(lim)) st = 1;
                else begin s += corr; n++; end
              end
            end
          end
          e_sum[e_n] = s; e_cnt[e_n] = n; e_flag[e_n] = (st == 1 && n == 0) ? 1 : 0;
          e_band[e_n] = sb; e_n++;
        end
      end
    end
  endtask

  task automatic stream(int mode, int nrows, int bp);
    int idx = 0, cyc = 0, idle = 0;
    int total = nrows * NC;
    g_n = 0;
    while (idx < total || idle < 40) begin
      @(negedge clk);
      case (bp)
        0: sp_ready = 1'b1;
        1: sp_ready = (cyc % 3) != 0;
        default: sp_ready = (cyc % 7) < 2;
      endcase
      if (idx < total) begin
        pix_valid = 1'b1;
        pix_row   = 4'(idx / NC);
        pix_col   = 4'(idx % NC);
        pix_data  = 16'(pixval(mode, idx / NC, idx % NC));
      end else begin
        pix_valid = 1'b0;
        idle++;
      end
      #1;
      if (sp_valid && sp_ready && g_n < 64) begin
        g_sum[g_n] = int'(sp_sum); g_cnt[g_n] = int'(sp_count);
        g_flag[g_n] = int'(sp_allsat); g_band[g_n] = int'(sp_band); g_n++;
      end
      if (sp_valid && !sp_ready && pix_ready) stall_err++;
      if (pix_valid && pix_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    pix_valid = 1'b0;
    sp_ready  = 1'b1;
  endtask

  task automatic pulse_frame;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic compare(string req);
    check(g_n == e_n, "R7", "spaxel count", g_n, e_n);
    for (int k = 0; k < e_n && k < g_n; k++) begin
      check(g_sum[k] == e_sum[k], req, $sformatf("sum[%0d]", k), g_sum[k], e_sum[k]);
      check(g_cnt[k] == e_cnt[k], req, $sformatf("count[%0d]", k), g_cnt[k], e_cnt[k]);
      check(g_flag[k] == e_flag[k], "R6", $sformatf("allsat[%0d]", k), g_flag[k], e_flag[k]);
      check(g_band[k] == e_band[k], "R7", $sformatf("band[%0d]", k), g_band[k], e_band[k]);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(sp_valid == 1'b0, "R10", "sp_valid after reset", int'(sp_valid), 0);
    check(pix_ready == 1'b1, "R10", "pix_ready after reset", int'(pix_ready), 1);

    // R4 R7: plain binning, full-width window, no stalls
    rf = 0; rl = 8; cf = 0; cl = 14; bias = 0; lim = 16'hFFFF; mask = '0;
    pulse_frame(); compute_exp(0, NR); stream(0, NR, 0); compare("R4");

    // R1 R2 R3 R5: offset ragged window, masked columns, bias, saturation
    rf = 1; rl = 7; cf = 2; cl = 12; bias = 20; lim = 150; mask = 16'h0221;
    pulse_frame(); compute_exp(1, NR); stream(1, NR, 1); compare("R1_R2_R3_R5");

    // R6 R9: every unmasked pixel saturated, heavy output stall
    rf = 3; rl = 8; cf = 3; cl = 8; bias = 0; lim = 1000; mask = 16'h0010;
    pulse_frame(); compute_exp(2, NR); stream(2, NR, 2); compare("R6");

    // R3: bias above every sample clamps to zero, pixels still counted
    rf = 0; rl = 5; cf = 0; cl = 5; bias = 16'hFFFF; lim = 10; mask = '0;
    pulse_frame(); compute_exp(3, NR); stream(3, NR, 1); compare("R3");

    // R8: abandoned frame, restart, then a full frame
    rf = 0; rl = 8; cf = 0; cl = 14; bias = 0; lim = 16'hFFFF; mask = '0;
    pulse_frame(); compute_exp(0, 5); stream(0, 5, 0); compare("R7");
    pulse_frame(); compute_exp(1, NR); stream(1, NR, 2); compare("R8");

    check(stall_err == 0, "R9", "pix_ready high while output stalled", stall_err, 0);

    summary();
    $finish;
  end

endmodule